// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block produces the raster timing for a parallel-RGB LCD panel. A horizontal counter runs on the pixel clock and a vertical counter advances once per line. Each edge of the frame is an absolute counter value, counted from the start of sync at zero: sync end, display start and total on each axis, plus a separate active width and height. From these values the block drives the horizontal and vertical sync pins, a data-enable, and the position of the current pixel inside the visible area.

The current line can be read back at any time. Three sticky status bits record the start of vertical sync, the first line of active video, and a programmable line match. Software clears each bit by writing a one to it. A mask selects which status bits drive a single interrupt line. A two-bit polarity control sets the active level of each sync pin independently. When the enable input is low, the counters are parked at zero and the status bits hold their values.

Top module: `lcd_timing_gen`

## Requirements
- R1: While reset is asserted and on the first sample after it is released, both counters and all status bits are zero, data-enable and the interrupt output are low, and both sync pins are at their inactive level.
- R2: With enable high, the horizontal count steps by one per clock and returns to 0 after reaching hTotal-1. A total of 0 or 1 holds it at 0. The vertical count steps once each time the horizontal count wraps and returns to 0 after reaching vTotal-1. curLine always shows the vertical count.
- R3: Horizontal sync is active while enable is high and the horizontal count is below hSyncEnd. Vertical sync is active while enable is high and the line count is below vSyncEnd.
- R4: syncPol bit 0 sets the hsync level and bit 1 sets the vsync level. A 0 makes the pin active-low (the reset default) and a 1 makes it active-high. When sync is not active, the pin sits at the opposite level.
- R5: deOut is high only when enable is high and both of these hold: hDispStart ≤ horizontal count < hDispStart+hActive, and vDispStart ≤ line < vDispStart+vActive.
- R6: While deOut is high, pixX equals the horizontal count minus hDispStart and pixY equals the line minus vDispStart. Both are 0 at all other times.
- R7: Status bit 0 (vsync start) is set on the clock after a cycle in which enable is high and both counters are 0.
- R8: Status bit 1 (display start) is set on the clock after an enabled cycle with horizontal count 0 and line equal to vDispStart.
- R9: Status bit 2 (line match) is set on the clock after an enabled cycle with horizontal count 0 and line equal to matchLine. A matchLine of vTotal or above never sets it.
- R10: A 1 on irqClear bit n clears status bit n at the next clock. If a set event and a clear arrive in the same cycle, the set wins.
- R11: irqOut is high exactly when some status bit and its irqMask bit are both 1.
- R12: While enable is low, both counters are held at 0, no status bit is set, and status bits change only through irqClear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the counters |
| hSyncEnd | input | CW | Horizontal count where sync ends |
| hDispStart | input | CW | Horizontal count of first active pixel |
| hActive | input | CW | Active pixels per line |
| hTotal | input | CW | Clocks per line |
| vSyncEnd | input | CW | Line where vertical sync ends |
| vDispStart | input | CW | First active line |
| vActive | input | CW | Active lines per frame |
| vTotal | input | CW | Lines per frame |
| matchLine | input | CW | Line that raises the match status |
| syncPol | input | 2 | Sync polarity, bit0 hsync, bit1 vsync |
| irqMask | input | 3 | Enables for status bits into irqOut |
| irqClear | input | 3 | Write-one-to-clear pulses |
| hsyncOut | output | 1 | Horizontal sync pin |
| vsyncOut | output | 1 | Vertical sync pin |
| deOut | output | 1 | Data enable |
| pixX | output | CW | Column within the active area |
| pixY | output | CW | Row within the active area |
| curLine | output | CW | Current line count |
| irqStatus | output | 3 | Sticky status bits |
| irqOut | output | 1 | Masked interrupt |

## Verification
The bench goes after the window edges on each axis. Zero-width porches put display start right at sync end, and an off-by-one compare there would stretch or clip data-enable by one pixel or one line, shift pixX, or leak sync into the active area. It also drives clears that land in the same cycle as a set event. A design where the clear wins would lose a vsync or match interrupt. Mid-frame disable pulses check that counters restart from the origin and that status is neither set nor lost while stopped. Match lines past the frame total and a mix of polarity settings catch false matches and swapped polarity bits.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;
  localparam int IRQ_BITS = 3;
  localparam int IRQ_VSYNC = 0;
  localparam int IRQ_DISP = 1;
  localparam int IRQ_MATCH = 2;

  // Strobes passed from the counter control to the output datapath
  typedef struct packed {
    logic run;        // counters are running this cycle
    logic evtVsync;   // first clock of the first line
    logic evtDisp;    // first clock of the first active line
    logic evtMatch;   // first clock of the programmed match line
  } tgStrobe_t;
endpackage

// File: rtl/lcd_tg_ctrl.sv
module lcd_tg_ctrl
  import lcd_timing_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic [CW-1:0] hTotal,
  input  logic [CW-1:0] vTotal,
  input  logic [CW-1:0] vDispStart,
  input  logic [CW-1:0] matchLine,
  output logic [CW-1:0] hCount,
  output logic [CW-1:0] vCount,
  output tgStrobe_t     strobe
);
  localparam int EW = CW + 1;

  logic [EW-1:0] hNext;
  logic [EW-1:0] vNext;
  logic hWrap;
  logic vWrap;
  logic atLineStart;

  // Compare one bit wider so that a total of 0 or 1 still wraps cleanly
  assign hNext = {1'b0, hCount} + EW'(1);
  assign vNext = {1'b0, vCount} + EW'(1);
  assign hWrap = hNext >= {1'b0, hTotal};
  assign vWrap = vNext >= {1'b0, vTotal};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCount <= '0;
      vCount <= '0;
    end else if (!enable) begin
      hCount <= '0;
      vCount <= '0;
    end else if (hWrap) begin
      hCount <= '0;
      vCount <= vWrap ? '0 : vNext[CW-1:0];
    end else begin
      hCount <= hNext[CW-1:0];
    end
  end

  assign atLineStart = enable && (hCount == '0);

  always_comb begin
    strobe.run      = enable;
    strobe.evtVsync = atLineStart && (vCount == '0);
    strobe.evtDisp  = atLineStart && (vCount == vDispStart);
    strobe.evtMatch = atLineStart && (vCount == matchLine);
  end

  // R12
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (hCount == '0 && vCount == '0));

  // R2
  vcnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !hWrap) |=> $stable(vCount));
endmodule

// File: rtl/lcd_tg_dp.sv
module lcd_tg_dp
  import lcd_timing_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  tgStrobe_t           strobe,
  input  logic [CW-1:0]       hCount,
  input  logic [CW-1:0]       vCount,
  input  logic [CW-1:0]       hSyncEnd,
  input  logic [CW-1:0]       hDispStart,
  input  logic [CW-1:0]       hActive,
  input  logic [CW-1:0]       vSyncEnd,
  input  logic [CW-1:0]       vDispStart,
  input  logic [CW-1:0]       vActive,
  input  logic [1:0]          syncPol,
  input  logic [IRQ_BITS-1:0] irqMask,
  input  logic [IRQ_BITS-1:0] irqClear,
  output logic                hsyncOut,
  output logic                vsyncOut,
  output logic                deOut,
  output logic [CW-1:0]       pixX,
  output logic [CW-1:0]       pixY,
  output logic [IRQ_BITS-1:0] irqStatus,
  output logic                irqOut
);
  localparam int EW = CW + 1;

  logic hsActive;
  logic vsActive;
  logic hInWin;
  logic vInWin;
  logic [EW-1:0] hDispEnd;
  logic [EW-1:0] vDispEnd;
  logic [IRQ_BITS-1:0] evtVec;

  assign hDispEnd = {1'b0, hDispStart} + {1'b0, hActive};
  assign vDispEnd = {1'b0, vDispStart} + {1'b0, vActive};

  assign hsActive = strobe.run && (hCount < hSyncEnd);
  assign vsActive = strobe.run && (vCount < vSyncEnd);
  assign hsyncOut = syncPol[0] ? hsActive : ~hsActive;
  assign vsyncOut = syncPol[1] ? vsActive : ~vsActive;

  assign hInWin = (hCount >= hDispStart) && ({1'b0, hCount} < hDispEnd);
  assign vInWin = (vCount >= vDispStart) && ({1'b0, vCount} < vDispEnd);
  assign deOut  = strobe.run && hInWin && vInWin;
  assign pixX   = deOut ? (hCount - hDispStart) : '0;
  assign pixY   = deOut ? (vCount - vDispStart) : '0;

  always_comb begin
    evtVec            = '0;
    evtVec[IRQ_VSYNC] = strobe.evtVsync;
    evtVec[IRQ_DISP]  = strobe.evtDisp;
    evtVec[IRQ_MATCH] = strobe.evtMatch;
  end

  // Set takes priority over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqStatus <= '0;
    else       irqStatus <= (irqStatus & ~irqClear) | evtVec;
  end

  assign irqOut = |(irqStatus & irqMask);

  // R7
  vs_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.evtVsync |=> irqStatus[IRQ_VSYNC]);

  // R10
  match_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqClear[IRQ_MATCH] && !strobe.evtMatch) |=> !irqStatus[IRQ_MATCH]);

  // R5
  de_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    deOut |-> strobe.run);
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_timing_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic [CW-1:0]       hSyncEnd,
  input  logic [CW-1:0]       hDispStart,
  input  logic [CW-1:0]       hActive,
  input  logic [CW-1:0]       hTotal,
  input  logic [CW-1:0]       vSyncEnd,
  input  logic [CW-1:0]       vDispStart,
  input  logic [CW-1:0]       vActive,
  input  logic [CW-1:0]       vTotal,
  input  logic [CW-1:0]       matchLine,
  input  logic [1:0]          syncPol,
  input  logic [IRQ_BITS-1:0] irqMask,
  input  logic [IRQ_BITS-1:0] irqClear,
  output logic                hsyncOut,
  output logic                vsyncOut,
  output logic                deOut,
  output logic [CW-1:0]       pixX,
  output logic [CW-1:0]       pixY,
  output logic [CW-1:0]       curLine,
  output logic [IRQ_BITS-1:0] irqStatus,
  output logic                irqOut
);
  logic [CW-1:0] hCount;
  logic [CW-1:0] vCount;
  tgStrobe_t strobe;

  lcd_tg_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .hTotal(hTotal), .vTotal(vTotal),
    .vDispStart(vDispStart), .matchLine(matchLine),
    .hCount(hCount), .vCount(vCount), .strobe(strobe)
  );

  lcd_tg_dp #(.CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .hCount(hCount), .vCount(vCount),
    .hSyncEnd(hSyncEnd), .hDispStart(hDispStart), .hActive(hActive),
    .vSyncEnd(vSyncEnd), .vDispStart(vDispStart), .vActive(vActive),
    .syncPol(syncPol), .irqMask(irqMask), .irqClear(irqClear),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut),
    .pixX(pixX), .pixY(pixY), .irqStatus(irqStatus), .irqOut(irqOut)
  );

  assign curLine = vCount;
endmodule

// File: tb/lcd_timing_gen_bench.sv
module lcd_timing_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;

  logic clk = 0;
  logic rstN = 0;
  logic enable = 0;
  logic [CW-1:0] hSyncEnd = 0, hDispStart = 0, hActive = 0, hTotal = 0;
  logic [CW-1:0] vSyncEnd = 0, vDispStart = 0, vActive = 0, vTotal = 0;
  logic [CW-1:0] matchLine = 0;
  logic [1:0] syncPol = 0;
  logic [2:0] irqMask = 0, irqClear = 0;
  logic hsyncOut, vsyncOut, deOut, irqOut;
  logic [CW-1:0] pixX, pixY, curLine;
  logic [2:0] irqStatus;

  int checks = 0;
  int errors = 0;
  bit chkOn = 0;
  bit done = 0;

  // reference state, built from the requirements
  int hm = 0, vm = 0;
  logic [2:0] expSt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_timing_gen #(.CW(CW)) u_lcd_timing_gen (
    .clk(clk), .rstN(rstN), .enable(enable),
    .hSyncEnd(hSyncEnd), .hDispStart(hDispStart), .hActive(hActive), .hTotal(hTotal),
    .vSyncEnd(vSyncEnd), .vDispStart(vDispStart), .vActive(vActive), .vTotal(vTotal),
    .matchLine(matchLine), .syncPol(syncPol), .irqMask(irqMask), .irqClear(irqClear),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut),
    .pixX(pixX), .pixY(pixY), .curLine(curLine), .irqStatus(irqStatus), .irqOut(irqOut)
  );

  function automatic logic [2:0] events();
    logic [2:0] e = 0;
    if (enable && hm == 0) begin
      e[0] = (vm == 0);
      e[1] = (vm == int'(vDispStart));
      e[2] = (vm == int'(matchLine));
    end
    return e;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hm <= 0; vm <= 0; expSt <= 0;
    end else begin
      expSt <= (expSt & ~irqClear) | events();
      if (!enable) begin
        hm <= 0; vm <= 0;
      end else if (hm + 1 >= int'(hTotal)) begin
        hm <= 0;
        vm <= (vm + 1 >= int'(vTotal)) ? 0 : vm + 1;
      end else hm <= hm + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit hsA, vsA, de;
    int ex, ey;
    hsA = enable && hm < int'(hSyncEnd);
    vsA = enable && vm < int'(vSyncEnd);
    de = enable && hm >= int'(hDispStart) && hm < int'(hDispStart) + int'(hActive)
         && vm >= int'(vDispStart) && vm < int'(vDispStart) + int'(vActive);
    ex = de ? hm - int'(hDispStart) : 0;
    ey = de ? vm - int'(vDispStart) : 0;
    check(int'(curLine) == vm, "R2 curLine", int'(curLine), vm);
    check(hsyncOut == (syncPol[0] ? hsA : !hsA), "R3/R4 hsync", hsyncOut, syncPol[0] ? hsA : !hsA);
    check(vsyncOut == (syncPol[1] ? vsA : !vsA), "R3/R4 vsync", vsyncOut, syncPol[1] ? vsA : !vsA);
    check(deOut == de, "R5 de", deOut, de);
    check(int'(pixX) == ex, "R6 pixX", int'(pixX), ex);
    check(int'(pixY) == ey, "R6 pixY", int'(pixY), ey);
    check(irqStatus == expSt, "R7 R8 R9 R10 R12 status", irqStatus, expSt);
    check(irqOut == |(expSt & irqMask), "R11 irqOut", irqOut, |(expSt & irqMask));
  endtask

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (chkOn && !done) compareAll();
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  task automatic randomConfig();
    int sl, bp, act, fp;
    sl = 1 + $urandom % 4; bp = $urandom % 4; act = 1 + $urandom % 8; fp = $urandom % 4;
    hSyncEnd = CW'(sl); hDispStart = CW'(sl + bp); hActive = CW'(act);
    hTotal = CW'(sl + bp + act + fp);
    sl = 1 + $urandom % 3; bp = $urandom % 3; act = 1 + $urandom % 6; fp = $urandom % 3;
    vSyncEnd = CW'(sl); vDispStart = CW'(sl + bp); vActive = CW'(act);
    vTotal = CW'(sl + bp + act + fp);
    matchLine = CW'($urandom % (int'(vTotal) + 2));
    syncPol = 2'($urandom); irqMask = 3'($urandom);
  endtask

  task automatic runCycles(input int n, input int clrRate);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      enable = ($urandom % 150) != 0;   // occasional mid-frame stop (R12)
      irqClear = ($urandom % clrRate == 0) ? 3'($urandom) : 3'b000;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state, default polarity active-low so pins idle high
    chkOn = 1;
    repeat (3) @(negedge clk);
    check(hsyncOut == 1 && vsyncOut == 1, "R1 sync idle", {hsyncOut, vsyncOut}, 3);
    check(deOut == 0 && irqOut == 0 && irqStatus == 0 && curLine == 0, "R1 outputs", irqStatus, 0);
    rstN = 1;
    @(negedge clk);
    check(irqStatus == 0 && curLine == 0, "R1 after release", irqStatus, 0);

    // Directed: zero porches, simultaneous clear of every bit (R10 set wins)
    hSyncEnd = 2; hDispStart = 2; hActive = 3; hTotal = 5;
    vSyncEnd = 1; vDispStart = 1; vActive = 2; vTotal = 3;
    matchLine = 0; syncPol = 2'b11; irqMask = 3'b111;
    @(negedge clk); enable = 1; irqClear = 3'b111;
    repeat (40) @(negedge clk);
    irqClear = 0;
    repeat (20) @(negedge clk);

    // Directed: total of 1 (R2) and match beyond the frame (R9)
    enable = 0; @(negedge clk);
    hTotal = 1; hSyncEnd = 1; hDispStart = 0; hActive = 1; matchLine = 9; vTotal = 4;
    enable = 1;
    repeat (20) @(negedge clk);
    enable = 0; irqClear = 3'b111; @(negedge clk);
    irqClear = 0;
    repeat (5) @(negedge clk);   // R12: held while stopped

    // Random configurations
    for (int c = 0; c < 14; c++) begin
      @(negedge clk); enable = 0;
      randomConfig();
      runCycles(3 * int'(hTotal) * int'(vTotal) + 10, 2 + c % 5);
    end
    @(negedge clk); enable = 0;
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule